// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers one-cycle event pulses from the submodules of a network controller into a sticky 32-bit interrupt status word. Each status bit has its own enable bit. Two global enable bits gate every source except the system-error source. The result is an active-low, level-sensitive interrupt line. A reloading software countdown timer is built in, and each time it expires it raises its own status bit.

Software uses a small register port with four word addresses. Address 0 is the status word, and a bit is cleared by writing 1 to it. Address 1 holds the per-bit enables. Address 2 is control: bit 0 is global enable A, bit 1 is global enable B, and bit 2 is the user-interrupt command. Address 3 is the timer reload value. Reads return data combinationally for the address currently presented.

Top module: `net_irq_aggregator`

## Requirements
- R1: Each event pulse sets one status bit at the next clock edge, and the bit stays set: receive is bit 0, software timer bit 4, transmit start bit 5, transmit done bit 6, user bit 7, transmit bit 8, system error bit 12, wake-up packet bit 13, suspend done bit 14, and management read error bit 16.
- R2: Writing address 0 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. If an event arrives in the same cycle as the clear of its bit, the bit stays set.
- R3: Only the bits listed in R1 exist. Every other bit of the status word and of the enable word reads 0, and writes to those bits are ignored.
- R4: For every source except system error, `irq_n` is 0 only while that source's status bit and enable bit are 1 and both global enables (control bits 0 and 1) are 1.
- R5: While status bit 12 and enable bit 12 are both 1, `irq_n` is 0 whatever the global enables hold.
- R6: A last-descriptor release always sets status bit 0. A first-descriptor release sets it only while `lookahead_en` is 1.
- R7: Status bit 16 is set only when `mgmt_ta_strobe` is 1 and `mgmt_line` is 1 in the same cycle. With `mgmt_line` at 0 the strobe has no effect.
- R8: Writing a non-zero value N to address 3 loads the timer. Bit 4 is then set at the Nth clock edge after the write, and again every N edges after that, because the timer reloads N in the same cycle it expires. A value of 0 stops the timer.
- R9: Writing control bit 2 as 1 sets status bit 7 one edge after the write edge. Control bit 2 always reads back as 0.
- R10: After reset, all registers read 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_rx_last | input | 1 | Last receive descriptor released |
| ev_rx_first | input | 1 | First receive descriptor released |
| lookahead_en | input | 1 | Allows first-descriptor receive interrupts |
| mgmt_ta_strobe | input | 1 | Turnaround slot of a management read |
| mgmt_line | input | 1 | Sampled management data line |
| ev_suspend | input | 1 | Suspend operation finished |
| ev_wake | input | 1 | Wake-up packet received |
| ev_sys_err | input | 1 | Bus system error detected |
| ev_tx | input | 1 | Transmit frame copied to FIFO |
| ev_tx_done | input | 1 | Transmission finished |
| ev_tx_start | input | 1 | Transmission started |
| irq_n | output | 1 | Interrupt, active low, level |

## Verification
Because reads are combinational, a wrong status bit shows up on `reg_rdata` right after the edge that should have set or cleared it. The same fault reaches `irq_n` in that cycle whenever the bit is enabled. A timer counter that is off by one moves the bit-4 set edge, and on later periods the drift grows. A leaked reserved bit, or an error in the global-enable gating, changes a port value on the very cycle it happens. For these reasons the reference model is compared against both outputs on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STAT_W = 32;
  localparam int B_RX   = 0;
  localparam int B_TMR  = 4;
  localparam int B_TXS  = 5;
  localparam int B_TXD  = 6;
  localparam int B_USER = 7;
  localparam int B_TX   = 8;
  localparam int B_SYS  = 12;
  localparam int B_WAKE = 13;
  localparam int B_SUSP = 14;
  localparam int B_MGMT = 16;

  function automatic logic [STAT_W-1:0] valid_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_RX] = 1'b1;  m[B_TMR] = 1'b1;  m[B_TXS] = 1'b1;  m[B_TXD] = 1'b1;
    m[B_USER] = 1'b1; m[B_TX] = 1'b1;  m[B_SYS] = 1'b1;  m[B_WAKE] = 1'b1;
    m[B_SUSP] = 1'b1; m[B_MGMT] = 1'b1;
    return m;
  endfunction

  // sticky bit with write-one-to-clear; a new event overrides the clear
  function automatic logic sticky_next(logic cur, logic clr, logic ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
  import irq_agg_pkg::*;
(
  input  logic              ev_rx_last,
  input  logic              ev_rx_first,
  input  logic              lookahead_en,
  input  logic              mgmt_ta_strobe,
  input  logic              mgmt_line,
  input  logic              ev_suspend,
  input  logic              ev_wake,
  input  logic              ev_sys_err,
  input  logic              ev_tx,
  input  logic              ev_tx_done,
  input  logic              ev_tx_start,
  input  logic              user_pend,
  input  logic              tmr_expire,
  output logic              rx_hit,
  output logic              mgmt_err,
  output logic [STAT_W-1:0] ev_vec
);
  assign rx_hit   = ev_rx_last | (ev_rx_first & lookahead_en);
  assign mgmt_err = mgmt_ta_strobe & mgmt_line;

  always_comb begin
    ev_vec         = '0;
    ev_vec[B_RX]   = rx_hit;
    ev_vec[B_TMR]  = tmr_expire;
    ev_vec[B_TXS]  = ev_tx_start;
    ev_vec[B_TXD]  = ev_tx_done;
    ev_vec[B_USER] = user_pend;
    ev_vec[B_TX]   = ev_tx;
    ev_vec[B_SYS]  = ev_sys_err;
    ev_vec[B_WAKE] = ev_wake;
    ev_vec[B_SUSP] = ev_suspend;
    ev_vec[B_MGMT] = mgmt_err;
  end
endmodule

// File: rtl/irq_sw_timer.sv
module irq_sw_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] reload_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  assign expire = (reload_q != '0) && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      reload_q <= load_val;
      cnt_q    <= load_val;
    end else if (expire) begin
      cnt_q    <= reload_q;
    end else if (reload_q != '0) begin
      cnt_q    <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] status_q
);
  localparam logic [STAT_W-1:0] KEEP = valid_mask();

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= sticky_next(q, clr_vec[i], ev_vec[i]);
      end
      assign status_q[i] = q;
    end else begin : g_tie
      assign status_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate
  import irq_agg_pkg::*;
(
  input  logic [STAT_W-1:0] status_q,
  input  logic [STAT_W-1:0] enable_q,
  input  logic              glob_a,
  input  logic              glob_b,
  output logic              sys_path,
  output logic              gen_path,
  output logic              irq_n
);
  localparam logic [STAT_W-1:0] GEN_MASK = valid_mask() & ~(STAT_W'(1) << B_SYS);

  assign sys_path = status_q[B_SYS] & enable_q[B_SYS];
  assign gen_path = (|(status_q & enable_q & GEN_MASK)) & glob_a & glob_b;
  assign irq_n    = ~(sys_path | gen_path);
endmodule

// File: rtl/net_irq_aggregator.sv
module net_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_rx_last,
  input  logic              ev_rx_first,
  input  logic              lookahead_en,
  input  logic              mgmt_ta_strobe,
  input  logic              mgmt_line,
  input  logic              ev_suspend,
  input  logic              ev_wake,
  input  logic              ev_sys_err,
  input  logic              ev_tx,
  input  logic              ev_tx_done,
  input  logic              ev_tx_start,
  output logic              irq_n
);
  localparam int PAD = STAT_W - TMR_W;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(3);

  logic              wr_stat, wr_en, wr_ctrl, wr_tmr;
  logic [STAT_W-1:0] clr_vec, ev_vec, status_q, enable_q;
  logic              glob_a, glob_b, user_pend;
  logic              rx_hit, mgmt_err, tmr_expire, sys_path, gen_path;
  logic [TMR_W-1:0]  tmr_reload;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_en   = reg_wr && (reg_addr == A_EN);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_tmr  = reg_wr && (reg_addr == A_TMR);
  assign clr_vec = wr_stat ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      glob_a    <= 1'b0;
      glob_b    <= 1'b0;
      user_pend <= 1'b0;
    end else begin
      if (wr_en) enable_q <= reg_wdata & valid_mask();
      if (wr_ctrl) begin
        glob_a <= reg_wdata[0];
        glob_b <= reg_wdata[1];
      end
      user_pend <= wr_ctrl && reg_wdata[2];
    end
  end

  irq_sw_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wr_tmr), .load_val(reg_wdata[TMR_W-1:0]),
    .reload_q(tmr_reload), .expire(tmr_expire)
  );

  irq_event_map u_map (
    .ev_rx_last(ev_rx_last), .ev_rx_first(ev_rx_first), .lookahead_en(lookahead_en),
    .mgmt_ta_strobe(mgmt_ta_strobe), .mgmt_line(mgmt_line), .ev_suspend(ev_suspend),
    .ev_wake(ev_wake), .ev_sys_err(ev_sys_err), .ev_tx(ev_tx), .ev_tx_done(ev_tx_done),
    .ev_tx_start(ev_tx_start), .user_pend(user_pend), .tmr_expire(tmr_expire),
    .rx_hit(rx_hit), .mgmt_err(mgmt_err), .ev_vec(ev_vec)
  );

  irq_sticky_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .clr_vec(clr_vec), .status_q(status_q)
  );

  irq_out_gate u_gate (
    .status_q(status_q), .enable_q(enable_q), .glob_a(glob_a), .glob_b(glob_b),
    .sys_path(sys_path), .gen_path(gen_path), .irq_n(irq_n)
  );

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_EN:    reg_rdata = enable_q;
      A_CTRL:  reg_rdata = {30'b0, glob_b, glob_a};
      A_TMR:   reg_rdata = {{PAD{1'b0}}, tmr_reload};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_sys_err,
  input logic              ev_rx_first,
  input logic              lookahead_en,
  input logic              mgmt_err,
  input logic              user_pend,
  input logic              tmr_expire,
  input logic              glob_a,
  input logic              glob_b,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] enable_q,
  input logic              irq_n
);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | enable_q) & ~valid_mask()) == '0);

  assert_event_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sys_err |=> status_q[B_SYS]);

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(status_q[B_SYS] && enable_q[B_SYS])) |-> (glob_a && glob_b));

  assert_sys_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_SYS] && enable_q[B_SYS]) |-> !irq_n);

  assert_rx_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_first && lookahead_en) |=> status_q[B_RX]);

  assert_mgmt_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_err |=> status_q[B_MGMT]);

  assert_timer_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> status_q[B_TMR]);

  assert_user_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    user_pend |=> status_q[B_USER]);
endmodule

bind net_irq_aggregator irq_agg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sys_err(ev_sys_err), .ev_rx_first(ev_rx_first),
  .lookahead_en(lookahead_en), .mgmt_err(mgmt_err), .user_pend(user_pend),
  .tmr_expire(tmr_expire), .glob_a(glob_a), .glob_b(glob_b),
  .status_q(status_q), .enable_q(enable_q), .irq_n(irq_n)
);

// File: tb/net_irq_aggregator_test.sv
module net_irq_aggregator_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;
  logic [8:0]  evs = '0;   // 0 rx_last 1 rx_first 2 mgmt strobe 3 suspend 4 wake 5 sys 6 tx 7 tx_done 8 tx_start
  logic        lookahead_en = 1'b0;
  logic        mgmt_line = 1'b0;

  net_irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_rx_last(evs[0]), .ev_rx_first(evs[1]),
    .lookahead_en(lookahead_en), .mgmt_ta_strobe(evs[2]), .mgmt_line(mgmt_line),
    .ev_suspend(evs[3]), .ev_wake(evs[4]), .ev_sys_err(evs[5]), .ev_tx(evs[6]),
    .ev_tx_done(evs[7]), .ev_tx_start(evs[8]), .irq_n(irq_n)
  );

  localparam logic [31:0] VALID = 32'h0001_71F1;
  int checks = 0, errors = 0;
  string cur_req = "R10";

  // behavioural reference model
  bit [31:0] m_stat, m_en;
  bit m_ga, m_gb, m_upend;
  int m_tval, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_ga = 0; m_gb = 0; m_upend = 0; m_tval = 0; m_cnt = 0;
    end else begin
      bit [31:0] ev, clr;
      ev = 0;
      if (evs[0] || (evs[1] && lookahead_en)) ev[0] = 1;
      if (evs[2] && mgmt_line) ev[16] = 1;
      if (evs[3]) ev[14] = 1;
      if (evs[4]) ev[13] = 1;
      if (evs[5]) ev[12] = 1;
      if (evs[6]) ev[8] = 1;
      if (evs[7]) ev[6] = 1;
      if (evs[8]) ev[5] = 1;
      if (m_upend) ev[7] = 1;
      if (m_tval != 0) begin
        if (m_cnt <= 1) begin ev[4] = 1; m_cnt = m_tval; end
        else m_cnt = m_cnt - 1;
      end
      clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata : 32'h0;
      m_stat = ((m_stat & ~clr) | ev) & VALID;
      m_upend = reg_wr && reg_addr == 2'd2 && reg_wdata[2];
      if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata & VALID;
      if (reg_wr && reg_addr == 2'd2) begin m_ga = reg_wdata[0]; m_gb = reg_wdata[1]; end
      if (reg_wr && reg_addr == 2'd3) begin m_tval = int'(reg_wdata[15:0]); m_cnt = m_tval; end
    end
  end

  function automatic bit m_irq_n();
    bit gen;
    gen = ((m_stat & m_en & ~32'h0000_1000) != 0) && m_ga && m_gb;
    return !((m_stat[12] && m_en[12]) || gen);
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_en;
      2'd2: return {30'b0, m_gb, m_ga};
      default: return m_tval[31:0];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    check({cur_req, " irq_n"}, {31'b0, irq_n}, {31'b0, m_irq_n()});
    check({cur_req, " rdata"}, reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic peek(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    reg_addr = 2'd0;
    #1;
  endtask

  task automatic pulse(int idx);
    evs = '0; evs[idx] = 1'b1;
    tick();
    evs = '0;
  endtask

  bit done = 0;
  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bitpos[9];
    bitpos = '{0, 0, 16, 14, 13, 12, 8, 6, 5};
    // R10 reset state
    tick(); tick();
    rst_n = 1'b1;
    tick();
    peek("R10 status", 2'd0, 32'h0);
    peek("R10 enable", 2'd1, 32'h0);
    peek("R10 ctrl", 2'd2, 32'h0);
    peek("R10 timer", 2'd3, 32'h0);
    check("R10 irq_n", {31'b0, irq_n}, 32'h1);

    // R1 bit positions, R7 mgmt with line high
    cur_req = "R1";
    mgmt_line = 1'b1;
    for (int i = 0; i < 9; i++) begin
      if (i == 1) continue;
      pulse(i);
      peek("R1 bit position", 2'd0, 32'h1 << bitpos[i]);
      wr(2'd0, 32'hFFFF_FFFF);
    end
    mgmt_line = 1'b0;

    // R2 clear one bit, event beats clear
    cur_req = "R2";
    evs = 9'h140; tick(); evs = '0;         // tx and tx_start
    wr(2'd0, 32'h0000_0020);
    peek("R2 partial clear", 2'd0, 32'h0000_0100);
    evs[6] = 1'b1; wr(2'd0, 32'h0000_0100); evs = '0;
    peek("R2 event wins", 2'd0, 32'h0000_0100);
    wr(2'd0, 32'hFFFF_FFFF);

    // R3 reserved bits
    cur_req = "R3";
    wr(2'd1, 32'hFFFF_FFFF);
    peek("R3 enable mask", 2'd1, 32'h0001_71F1);
    wr(2'd1, 32'h0);
    peek("R3 status reserved", 2'd0, 32'h0);

    // R4 global gating
    cur_req = "R4";
    wr(2'd1, 32'h0000_0100);
    wr(2'd2, 32'h1);
    pulse(6);
    check("R4 one global", {31'b0, irq_n}, 32'h1);
    wr(2'd2, 32'h3);
    check("R4 both globals", {31'b0, irq_n}, 32'h0);
    wr(2'd1, 32'h0);
    check("R4 enable off", {31'b0, irq_n}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);

    // R5 system error bypass
    cur_req = "R5";
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0000_1000);
    pulse(5);
    check("R5 bypass globals", {31'b0, irq_n}, 32'h0);
    wr(2'd0, 32'h0000_1000);
    check("R5 cleared", {31'b0, irq_n}, 32'h1);
    wr(2'd1, 32'h0);

    // R6 look-ahead receive
    cur_req = "R6";
    pulse(1);
    peek("R6 first without lookahead", 2'd0, 32'h0);
    lookahead_en = 1'b1;
    pulse(1);
    peek("R6 first with lookahead", 2'd0, 32'h1);
    lookahead_en = 1'b0;
    wr(2'd0, 32'hFFFF_FFFF);

    // R7 mgmt with line low
    cur_req = "R7";
    pulse(2);
    peek("R7 line low ignored", 2'd0, 32'h0);
    mgmt_line = 1'b1; pulse(2); mgmt_line = 1'b0;
    peek("R7 line high", 2'd0, 32'h0001_0000);
    wr(2'd0, 32'hFFFF_FFFF);

    // R8 software timer
    cur_req = "R8";
    wr(2'd3, 32'd5);
    for (int k = 0; k < 4; k++) tick();
    peek("R8 before expiry", 2'd0, 32'h0);
    tick();
    peek("R8 expiry at 5th edge", 2'd0, 32'h10);
    wr(2'd0, 32'h10);
    for (int k = 0; k < 3; k++) tick();
    peek("R8 reload pending", 2'd0, 32'h0);
    tick();
    peek("R8 reload period", 2'd0, 32'h10);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    for (int k = 0; k < 20; k++) tick();
    peek("R8 zero stops", 2'd0, 32'h0);

    // R9 user command
    cur_req = "R9";
    wr(2'd2, 32'h7);
    peek("R9 not yet", 2'd0, 32'h0);
    peek("R9 cmd reads zero", 2'd2, 32'h3);
    tick();
    peek("R9 set one later", 2'd0, 32'h80);
    wr(2'd1, 32'h80);
    check("R9 irq", {31'b0, irq_n}, 32'h0);
    for (int k = 0; k < 4; k++) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule